// File: doc/BRIEF.md
# Static Branch Predictor and Resolver

This block serves the decode and execute stages of a small in-order integer core that has no dynamic prediction hardware. In the decode cycle it inspects one 32-bit instruction with its program counter. It recognises conditional branches, direct jumps and register-indirect jumps, and it gives a taken or not-taken guess with the next fetch address that follows from that guess. For a conditional branch the guess comes from one instruction bit, the sign of the encoded offset. A backward branch is guessed taken and a forward branch is guessed to fall through.

On the next clock edge the decoded control-flow information moves into an internal execute-stage register. In that cycle the core supplies the two integer register operands. The block evaluates the branch condition as a fused compare-and-jump with no flags register. It raises a mispredict flag when the outcome differs from the earlier guess and gives the address that fetch must restart from. No instruction in a shadow slot is ever assumed to execute. Flushing, fetch and any prediction tables belong to other blocks.

Top module: `static_bpred`

## Requirements
- R1: A valid conditional branch (opcode 1100011) with instruction bit 31 set (negative offset) is guessed taken, and its predicted PC is the branch's own PC plus the sign-extended offset {inst[31], inst[7], inst[30:25], inst[11:8], 0}.
- R2: A conditional branch with bit 31 clear (zero or positive offset) is guessed not taken, and its predicted PC is PC+4.
- R3: funct3 picks the condition: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. The branch opcode with funct3 010 or 011 is not treated as control flow (dec_is_ctrl low, no guess, no mispredict).
- R4: Signed conditions read the operands as two's complement and unsigned conditions read them as plain binary, including at 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF.
- R5: In the execute cycle ex_taken gives the resolved outcome and ex_mispredict is high exactly when it differs from the decode guess. ex_redirect_pc is the branch target when taken and PC+4 otherwise.
- R6: A direct jump (opcode 1101111) is guessed taken at decode to PC plus the sign-extended offset {inst[31], inst[19:12], inst[20], inst[30:21], 0}. It never mispredicts, and ex_link_pc is PC+4.
- R7: A register-indirect jump (opcode 1100111, funct3 000) is guessed not taken at decode. In execute it always mispredicts, with ex_redirect_pc = (rs1 + sign-extended inst[31:20]) with bit 0 cleared, and ex_link_pc = PC+4. Other funct3 values on that opcode are not control flow.
- R8: The execute cycle reports the instruction presented with dec_valid one cycle earlier. A bubble (dec_valid low) or a non-control instruction never raises ex_mispredict or ex_taken.
- R9: While rst_n is low, ex_valid, ex_taken and ex_mispredict are low whatever the decode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_inst | input | 32 | Instruction word at decode |
| dec_pc | input | XLEN | Address of the decode instruction |
| dec_is_ctrl | output | 1 | Decode instruction is a recognised branch or jump |
| dec_pred_taken | output | 1 | Static guess for the decode instruction |
| dec_pred_pc | output | XLEN | Next fetch address under that guess |
| ex_rs1 | input | XLEN | First register operand for the execute instruction |
| ex_rs2 | input | XLEN | Second register operand for the execute instruction |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_taken | output | 1 | Resolved control transfer |
| ex_mispredict | output | 1 | Resolved outcome differs from the guess |
| ex_redirect_pc | output | XLEN | Correct next address for the execute instruction |
| ex_link_pc | output | XLEN | Return address, PC+4 of the execute instruction |

## Verification
The assertions assume that the decode inputs hold defined values whenever rst_n is high, and that ex_rs1 and ex_rs2 belong to the instruction that was in decode one edge earlier. The bench changes every input only on the falling clock edge. It follows each instruction with a bubble cycle, and it applies that instruction's operands only in the bubble cycle. Because of this, every execute result lines up with exactly one decode guess and no operand is shared between two instructions.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

   typedef enum logic [1:0] {
      CF_NONE = 2'd0,
      CF_COND = 2'd1,
      CF_JAL  = 2'd2,
      CF_JALR = 2'd3
   } cf_kind_e;

   localparam int ILEN = 32;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;

   // condition base selected by funct3[2:1]; funct3[0] inverts it
   localparam logic [1:0] CB_EQ  = 2'b00;
   localparam logic [1:0] CB_LT  = 2'b10;
   localparam logic [1:0] CB_LTU = 2'b11;

endpackage

// File: rtl/bpr_decode.sv
module bpr_decode
   import bpr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              valid,
   input  logic [ILEN-1:0]   inst,
   input  logic [XLEN-1:0]   pc,
   output cf_kind_e          kind,
   output logic [2:0]        funct3,
   output logic [XLEN-1:0]   target,
   output logic [XLEN-1:0]   imm_i,
   output logic              pred_taken,
   output logic [XLEN-1:0]   pred_pc
);

   localparam int BIMM_W = 13;
   localparam int JIMM_W = 21;
   localparam int IIMM_W = 12;

   logic [6:0]      opcode;
   logic [XLEN-1:0] imm_b;
   logic [XLEN-1:0] imm_j;
   logic [XLEN-1:0] fall_pc;
   logic            sign_bit;

   assign opcode   = inst[6:0];
   assign funct3   = inst[14:12];
   assign sign_bit = inst[ILEN-1];

   assign imm_b = {{(XLEN-BIMM_W){sign_bit}}, sign_bit, inst[7],
                   inst[30:25], inst[11:8], 1'b0};
   assign imm_j = {{(XLEN-JIMM_W){sign_bit}}, sign_bit, inst[19:12],
                   inst[20], inst[30:21], 1'b0};
   assign imm_i = {{(XLEN-IIMM_W){sign_bit}}, inst[31:20]};

   always_comb begin
      kind = CF_NONE;
      unique case (opcode)
         OPC_BRANCH: if (funct3[2:1] != 2'b01) kind = CF_COND;
         OPC_JAL:    kind = CF_JAL;
         OPC_JALR:   if (funct3 == 3'b000) kind = CF_JALR;
         default:    kind = CF_NONE;
      endcase
      if (!valid) kind = CF_NONE;
   end

   assign target  = pc + ((kind == CF_JAL) ? imm_j : imm_b);
   assign fall_pc = pc + XLEN'(4);

   // backward conditional branches and direct jumps are guessed taken
   assign pred_taken = ((kind == CF_COND) && sign_bit) || (kind == CF_JAL);
   assign pred_pc    = pred_taken ? target : fall_pc;

endmodule

// File: rtl/bpr_compare.sv
module bpr_compare
   import bpr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [2:0]      funct3,
   output logic            hit
);

   logic is_eq;
   logic is_lt;
   logic is_ltu;
   logic base;

   assign is_eq = (a == b);

   generate
      if (SHARED_SUB) begin : g_shared
         logic [XLEN:0] diff;
         assign diff   = {1'b0, a} - {1'b0, b};
         assign is_ltu = diff[XLEN];
         // signs differ: the negative one is smaller; else unsigned order holds
         assign is_lt  = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN];
      end else begin : g_split
         assign is_ltu = (a < b);
         assign is_lt  = ($signed(a) < $signed(b));
      end
   endgenerate

   always_comb begin
      unique case (funct3[2:1])
         CB_EQ:   base = is_eq;
         CB_LT:   base = is_lt;
         CB_LTU:  base = is_ltu;
         default: base = 1'b0;
      endcase
   end

   assign hit = base ^ funct3[0];

endmodule

// File: rtl/bpr_stage.sv
module bpr_stage
   import bpr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            d_valid,
   input  cf_kind_e        d_kind,
   input  logic [2:0]      d_funct3,
   input  logic [XLEN-1:0] d_pc,
   input  logic [XLEN-1:0] d_target,
   input  logic [XLEN-1:0] d_imm_i,
   input  logic            d_pred,
   output logic            q_valid,
   output cf_kind_e        q_kind,
   output logic [2:0]      q_funct3,
   output logic [XLEN-1:0] q_pc,
   output logic [XLEN-1:0] q_target,
   output logic [XLEN-1:0] q_imm_i,
   output logic            q_pred
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_kind  <= CF_NONE;
         q_pred  <= 1'b0;
      end else begin
         q_valid <= d_valid;
         q_kind  <= d_kind;
         q_pred  <= d_pred;
      end
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_funct3 <= '0;
               q_pc     <= '0;
               q_target <= '0;
               q_imm_i  <= '0;
            end else begin
               q_funct3 <= d_funct3;
               q_pc     <= d_pc;
               q_target <= d_target;
               q_imm_i  <= d_imm_i;
            end
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            q_funct3 <= d_funct3;
            q_pc     <= d_pc;
            q_target <= d_target;
            q_imm_i  <= d_imm_i;
         end
      end
   endgenerate

   // R8: execute slot carries what decode offered one edge earlier
   p_stage_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q_valid == $past(d_valid)));

   p_stage_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q_kind == $past(d_kind)));

endmodule

// File: rtl/static_bpred.sv
module static_bpred
   import bpr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_SUB = 1'b1,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_valid,
   input  logic [31:0]     dec_inst,
   input  logic [XLEN-1:0] dec_pc,
   output logic            dec_is_ctrl,
   output logic            dec_pred_taken,
   output logic [XLEN-1:0] dec_pred_pc,
   input  logic [XLEN-1:0] ex_rs1,
   input  logic [XLEN-1:0] ex_rs2,
   output logic            ex_valid,
   output logic            ex_taken,
   output logic            ex_mispredict,
   output logic [XLEN-1:0] ex_redirect_pc,
   output logic [XLEN-1:0] ex_link_pc
);

   initial begin
      p_xlen_legal: assert (XLEN == 32 || XLEN == 64)
         else $error("static_bpred: XLEN must be 32 or 64");
   end

   cf_kind_e        d_kind;
   logic [2:0]      d_funct3;
   logic [XLEN-1:0] d_target;
   logic [XLEN-1:0] d_imm_i;

   cf_kind_e        q_kind;
   logic [2:0]      q_funct3;
   logic [XLEN-1:0] q_pc;
   logic [XLEN-1:0] q_target;
   logic [XLEN-1:0] q_imm_i;
   logic            q_pred;
   logic            q_valid;

   logic            cmp_hit;
   logic            rs_taken;
   logic [XLEN-1:0] rs_target;
   logic [XLEN-1:0] jalr_sum;

   bpr_decode #(.XLEN(XLEN)) u_dec (
      .valid      (dec_valid),
      .inst       (dec_inst),
      .pc         (dec_pc),
      .kind       (d_kind),
      .funct3     (d_funct3),
      .target     (d_target),
      .imm_i      (d_imm_i),
      .pred_taken (dec_pred_taken),
      .pred_pc    (dec_pred_pc)
   );

   assign dec_is_ctrl = (d_kind != CF_NONE);

   bpr_stage #(.XLEN(XLEN), .RESET_DATA(RESET_DATA)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_valid  (dec_valid),
      .d_kind   (d_kind),
      .d_funct3 (d_funct3),
      .d_pc     (dec_pc),
      .d_target (d_target),
      .d_imm_i  (d_imm_i),
      .d_pred   (dec_pred_taken),
      .q_valid  (q_valid),
      .q_kind   (q_kind),
      .q_funct3 (q_funct3),
      .q_pc     (q_pc),
      .q_target (q_target),
      .q_imm_i  (q_imm_i),
      .q_pred   (q_pred)
   );

   bpr_compare #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
      .a      (ex_rs1),
      .b      (ex_rs2),
      .funct3 (q_funct3),
      .hit    (cmp_hit)
   );

   assign jalr_sum = ex_rs1 + q_imm_i;

   always_comb begin
      unique case (q_kind)
         CF_COND: begin rs_taken = cmp_hit; rs_target = q_target; end
         CF_JAL:  begin rs_taken = 1'b1;    rs_target = q_target; end
         CF_JALR: begin rs_taken = 1'b1;    rs_target = {jalr_sum[XLEN-1:1], 1'b0}; end
         default: begin rs_taken = 1'b0;    rs_target = q_target; end
      endcase
   end

   assign ex_valid       = q_valid;
   assign ex_link_pc     = q_pc + XLEN'(4);
   assign ex_taken       = q_valid && rs_taken;
   assign ex_mispredict  = q_valid && (q_kind != CF_NONE) && (rs_taken != q_pred);
   assign ex_redirect_pc = rs_taken ? rs_target : ex_link_pc;

   // R1: backward conditional branch guessed taken
   p_backward_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (d_kind == CF_COND && dec_inst[31]) |-> dec_pred_taken);

   // R2: forward conditional branch falls through to the next word
   p_forward_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_kind == CF_COND && !dec_inst[31]) |->
         (!dec_pred_taken && dec_pred_pc == dec_pc + XLEN'(4)));

   // R5: a not-taken outcome restarts at the sequential address
   p_fall_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && !ex_taken) |-> (ex_redirect_pc == ex_link_pc));

   // R6: direct jumps never mispredict
   p_jal_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && q_kind == CF_JAL) |-> (ex_taken && !ex_mispredict));

   // R7: indirect jumps always redirect to a halfword-aligned address
   p_jalr_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && q_kind == CF_JALR) |-> (ex_mispredict && !ex_redirect_pc[0]));

   // R8: an empty execute slot stays quiet
   p_bubble_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |-> (!ex_mispredict && !ex_taken));

endmodule

// File: tb/tb_static_bpred.sv
`timescale 1ns/1ps
module tb_static_bpred;

   localparam int  XLEN = 32;
   localparam time TCK  = 20ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            dec_valid = 1'b0;
   logic [31:0]     dec_inst = 32'h0000_0013;
   logic [XLEN-1:0] dec_pc = '0;
   logic            dec_is_ctrl;
   logic            dec_pred_taken;
   logic [XLEN-1:0] dec_pred_pc;
   logic [XLEN-1:0] ex_rs1 = '0;
   logic [XLEN-1:0] ex_rs2 = '0;
   logic            ex_valid;
   logic            ex_taken;
   logic            ex_mispredict;
   logic [XLEN-1:0] ex_redirect_pc;
   logic [XLEN-1:0] ex_link_pc;

   static_bpred #(.XLEN(XLEN)) dut (
      .clk, .rst_n, .dec_valid, .dec_inst, .dec_pc, .dec_is_ctrl,
      .dec_pred_taken, .dec_pred_pc, .ex_rs1, .ex_rs2, .ex_valid,
      .ex_taken, .ex_mispredict, .ex_redirect_pc, .ex_link_pc
   );

   always #(TCK/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [12:0] off);
      return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
   endfunction

   function automatic logic [31:0] enc_j(input logic [20:0] off);
      return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
   endfunction

   function automatic logic [31:0] enc_i(input logic [2:0] f3, input logic [11:0] imm);
      return {imm, 5'd1, f3, 5'd1, 7'b1100111};
   endfunction

   task automatic issue(input logic v, input logic [31:0] inst, input logic [31:0] pc);
      @(negedge clk);
      dec_valid = v;
      dec_inst  = inst;
      dec_pc    = pc;
      #2;
   endtask

   task automatic execute(input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      dec_valid = 1'b0;
      dec_inst  = 32'h0000_0013;
      ex_rs1    = a;
      ex_rs2    = b;
      #2;
   endtask

   typedef struct packed {
      logic [2:0]  f3;
      logic [12:0] off;
      logic [31:0] a;
      logic [31:0] b;
      logic        tk;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{3'b000, -13'sd8,    32'd5,         32'd5,         1'b1},
      '{3'b000, 13'sd16,    32'd5,         32'd6,         1'b0},
      '{3'b000, 13'sd16,    32'd7,         32'd7,         1'b1},
      '{3'b001, -13'sd4,    32'd1,         32'd2,         1'b1},
      '{3'b001, -13'sd4,    32'd3,         32'd3,         1'b0},
      '{3'b100, 13'sd8,     32'h8000_0000, 32'd0,         1'b1},
      '{3'b100, -13'sd8,    32'd0,         32'h8000_0000, 1'b0},
      '{3'b100, -13'sd12,   32'hFFFF_FFFF, 32'd0,         1'b1},
      '{3'b101, 13'sd8,     32'h7FFF_FFFF, 32'h8000_0000, 1'b1},
      '{3'b101, -13'sd16,   32'd5,         32'd5,         1'b1},
      '{3'b101, 13'sd20,    32'hFFFF_FFFF, 32'd0,         1'b0},
      '{3'b110, 13'sd8,     32'd0,         32'hFFFF_FFFF, 1'b1},
      '{3'b110, -13'sd8,    32'h8000_0000, 32'h7FFF_FFFF, 1'b0},
      '{3'b110, -13'sd8,    32'd1,         32'd1,         1'b0},
      '{3'b111, 13'sd12,    32'hFFFF_FFFF, 32'd0,         1'b1},
      '{3'b111, -13'sd4096, 32'd0,         32'h8000_0000, 1'b0},
      '{3'b111, 13'sd4094,  32'd9,         32'd9,         1'b1},
      '{3'b000, 13'sd0,     32'd0,         32'd0,         1'b1}
   };

   logic [31:0] pc_v;
   logic [31:0] off_v;
   logic        gp;
   logic [31:0] gpc;
   string       rq;

   initial begin
      // R9: reset holds the execute slot empty while decode is busy
      dec_valid = 1'b1;
      dec_inst  = enc_b(3'b000, -13'sd8);
      dec_pc    = 32'h100;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "ex_valid in reset", {31'd0, ex_valid}, 32'd0);
      chk("R9", "ex_mispredict in reset", {31'd0, ex_mispredict}, 32'd0);
      chk("R9", "ex_taken in reset", {31'd0, ex_taken}, 32'd0);
      dec_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "ex_valid after reset", {31'd0, ex_valid}, 32'd0);

      // table walk: R1..R5 over every condition code
      for (int i = 0; i < NV; i++) begin
         pc_v  = 32'h1000 + 32'(i) * 32'h40;
         off_v = {{19{VECS[i].off[12]}}, VECS[i].off};
         gp    = VECS[i].off[12];
         gpc   = gp ? pc_v + off_v : pc_v + 32'd4;
         rq    = gp ? "R1" : "R2";
         issue(1'b1, enc_b(VECS[i].f3, VECS[i].off), pc_v);
         chk("R3", $sformatf("v%0d is_ctrl", i), {31'd0, dec_is_ctrl}, 32'd1);
         chk(rq, $sformatf("v%0d pred_taken", i), {31'd0, dec_pred_taken}, {31'd0, gp});
         chk(rq, $sformatf("v%0d pred_pc", i), dec_pred_pc, gpc);
         execute(VECS[i].a, VECS[i].b);
         chk("R4", $sformatf("v%0d taken", i), {31'd0, ex_taken}, {31'd0, VECS[i].tk});
         chk("R5", $sformatf("v%0d mispredict", i), {31'd0, ex_mispredict},
             {31'd0, VECS[i].tk != gp});
         chk("R5", $sformatf("v%0d redirect", i), ex_redirect_pc,
             VECS[i].tk ? pc_v + off_v : pc_v + 32'd4);
         chk("R8", $sformatf("v%0d ex_valid", i), {31'd0, ex_valid}, 32'd1);
      end

      // R6: direct jumps, forward and backward
      issue(1'b1, enc_j(21'sd2048), 32'h4000);
      chk("R6", "jal fwd pred", {31'd0, dec_pred_taken}, 32'd1);
      chk("R6", "jal fwd pc", dec_pred_pc, 32'h4800);
      execute(32'hDEAD_0000, 32'd0);
      chk("R6", "jal fwd mispredict", {31'd0, ex_mispredict}, 32'd0);
      chk("R6", "jal fwd taken", {31'd0, ex_taken}, 32'd1);
      chk("R6", "jal fwd link", ex_link_pc, 32'h4004);
      issue(1'b1, enc_j(-21'sd20), 32'h4000);
      chk("R6", "jal back pc", dec_pred_pc, 32'h3FEC);
      execute(32'd0, 32'd0);
      chk("R6", "jal back mispredict", {31'd0, ex_mispredict}, 32'd0);

      // R7: indirect jumps
      issue(1'b1, enc_i(3'b000, 12'd6), 32'h5000);
      chk("R7", "jalr pred", {31'd0, dec_pred_taken}, 32'd0);
      chk("R7", "jalr pred pc", dec_pred_pc, 32'h5004);
      execute(32'h2003, 32'd0);
      chk("R7", "jalr mispredict", {31'd0, ex_mispredict}, 32'd1);
      chk("R7", "jalr redirect", ex_redirect_pc, 32'h2008);
      chk("R7", "jalr link", ex_link_pc, 32'h5004);
      issue(1'b1, enc_i(3'b000, 12'hFFF), 32'h5100);
      execute(32'h3000, 32'd0);
      chk("R7", "jalr neg redirect", ex_redirect_pc, 32'h2FFE);
      issue(1'b1, enc_i(3'b001, 12'd6), 32'h5200);
      chk("R7", "jalr bad funct3 ctrl", {31'd0, dec_is_ctrl}, 32'd0);
      execute(32'h2003, 32'd0);
      chk("R7", "jalr bad funct3 mispredict", {31'd0, ex_mispredict}, 32'd0);

      // R3: reserved branch funct3 with a backward offset
      issue(1'b1, enc_b(3'b010, -13'sd8), 32'h6000);
      chk("R3", "f3=010 ctrl", {31'd0, dec_is_ctrl}, 32'd0);
      chk("R3", "f3=010 pred", {31'd0, dec_pred_taken}, 32'd0);
      chk("R3", "f3=010 pred pc", dec_pred_pc, 32'h6004);
      execute(32'd4, 32'd4);
      chk("R3", "f3=010 mispredict", {31'd0, ex_mispredict}, 32'd0);
      chk("R3", "f3=010 taken", {31'd0, ex_taken}, 32'd0);

      // R8: plain ALU word with bit 31 set, and an empty decode slot
      issue(1'b1, 32'hFFF0_0093, 32'h7000);
      chk("R8", "alu ctrl", {31'd0, dec_is_ctrl}, 32'd0);
      execute(32'd1, 32'd1);
      chk("R8", "alu mispredict", {31'd0, ex_mispredict}, 32'd0);
      issue(1'b0, enc_b(3'b000, -13'sd8), 32'h7100);
      chk("R8", "bubble pred", {31'd0, dec_pred_taken}, 32'd0);
      execute(32'd1, 32'd1);
      chk("R8", "bubble ex_valid", {31'd0, ex_valid}, 32'd0);
      chk("R8", "bubble mispredict", {31'd0, ex_mispredict}, 32'd0);
      chk("R8", "bubble taken", {31'd0, ex_taken}, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(TCK * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule